// File: doc/BRIEF.md
# Eight-Level Prioritized Interrupt Controller

This block collects eight peripheral interrupt request lines and tells one processor which of them to serve next. It holds three 8-bit registers: pending requests, levels currently in service, and a mask. A priority resolver picks the most urgent pending request that is not masked. It raises `int_o` only when that request strictly outranks every level already in service, so a handler can be interrupted only by something more urgent.

When the processor pulses `ack` while `int_o` is high, the granted level is marked in service. The vector on `vec_o` combines a programmable base with the level number. Software ends a handler with an end-of-interrupt command. That command either names a level or clears the most urgent one in service.

Software uses a small register interface. Write addresses: 0 sets the mask, 1 sets the vector base, 2 sets the per-line trigger mode, 3 sets the priority mode, and 4 issues an end-of-interrupt. Read addresses: 0 returns pending, 1 returns in-service, 2 returns the mask, and 3 returns a poll result. Priority is either fixed or rotating. Each line is independently edge- or level-sensitive.

Top module: `irq_arbiter8`

## Requirements
- R1: A request whose bit is 1 in the mask (write address 0, read address 2) never raises `int_o`, but it still shows as 1 in the pending read (read address 0).
- R2: Trigger mode is set through write address 2, where bit i = 1 makes line i edge-sensitive. An edge-sensitive pending bit sets one clock after a low-to-high transition and stays set after the line drops. A level-sensitive pending bit follows the line one clock later.
- R3: `int_o` is 1 exactly when an unmasked pending level exists whose priority is strictly higher than every in-service level. A request for a level that is already in service never raises it.
- R4: A one-cycle `ack` while `int_o` is 1 sets the in-service bit of the granted level at the next clock and clears that level's edge-sensitive pending bit. An `ack` while `int_o` is 0 changes nothing.
- R5: While `int_o` is 1, `vec_o` equals {base[7:3], level[2:0]}. Base is the value last written to address 1.
- R6: Fixed priority is selected by bit 0 of write address 3 being 0, which is also the reset value. In this mode level 0 is most urgent and level 7 least.
- R7: Rotating priority is selected by bit 0 of write address 3 being 1. After an end-of-interrupt for level L, L becomes the least urgent level and (L+1) mod 8 the most urgent.
- R8: An end-of-interrupt is a write to address 4. With data bit 3 = 0 it clears the most urgent in-service bit. With data bit 3 = 1 it clears the in-service bit of the level in data bits 2:0. In-service bits clear by no other means.
- R9: The poll read (address 3) returns {1, 0000, level} for the most urgent unmasked pending level, or 0 when none exists, and has no side effect.
- R10: After reset, pending, in-service and mask are 0, all lines are edge-sensitive, priority is fixed, the base is 0 and `int_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Peripheral request lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Read data (combinational) |
| ack | input | 1 | Processor acknowledge pulse |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector for the granted level |

## Verification
A change on a request line reaches the pending register at the next clock. From there it drives `int_o`, `vec_o` and the poll read combinationally in that same cycle. Acknowledges, end-of-interrupt commands and register writes likewise take effect at the first clock after they are driven. The bench therefore drives every input just after a falling edge and reads results at the following falling edge, exactly one rising edge later. Reads are combinational and are sampled a short delay after setting the read address.

// File: rtl/irq_arbiter8.sv
module irq_arbiter8 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] irq_in,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       ack,
  output logic       int_o,
  output logic [7:0] vec_o
);

  logic [7:0] irq_q, irr, isr, mask, trig;
  logic [4:0] base_hi;
  logic       rotate;
  logic [2:0] lowp;

  function automatic logic [3:0] top_of(input logic [7:0] v, input logic [2:0] s);
    logic [3:0] r;
    logic [2:0] idx;
    r = 4'd0;
    for (int k = 7; k >= 0; k--) begin
      idx = s + 3'(k);
      if (v[idx]) r = {1'b1, idx};
    end
    return r;
  endfunction

  logic [2:0] start;
  logic [7:0] req;
  logic       req_ok, isr_any;
  logic [2:0] req_lvl, isr_lvl, req_rank, isr_rank;

  assign start = rotate ? lowp + 3'd1 : 3'd0;
  assign req   = irr & ~mask;
  assign {req_ok, req_lvl} = top_of(req, start);
  assign {isr_any, isr_lvl} = top_of(isr, start);
  assign req_rank = req_lvl - start;
  assign isr_rank = isr_lvl - start;

  assign int_o = req_ok && (!isr_any || req_rank < isr_rank);
  assign vec_o = {base_hi, req_lvl};

  logic       grant, eoi, eoi_hit;
  logic [2:0] eoi_lvl;
  logic [7:0] isr_set, isr_clr, rise;

  assign grant   = ack && int_o;
  assign eoi     = wr_en && wr_addr == 3'd4;
  assign eoi_lvl = wr_data[3] ? wr_data[2:0] : isr_lvl;
  assign eoi_hit = eoi && (wr_data[3] || isr_any);
  assign isr_set = grant ? 8'b1 << req_lvl : 8'd0;
  assign isr_clr = eoi_hit ? 8'b1 << eoi_lvl : 8'd0;
  assign rise    = irq_in & ~irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q   <= 8'd0;
      irr     <= 8'd0;
      isr     <= 8'd0;
      mask    <= 8'd0;
      trig    <= 8'hFF;
      base_hi <= 5'd0;
      rotate  <= 1'b0;
      lowp    <= 3'd7;
    end else begin
      irq_q <= irq_in;
      irr   <= (trig & ((irr & ~isr_set) | rise)) | (~trig & irq_in);
      isr   <= (isr & ~isr_clr) | isr_set;
      if (eoi_hit && rotate) lowp <= eoi_lvl;
      if (wr_en) begin
        case (wr_addr)
          3'd0: mask    <= wr_data;
          3'd1: base_hi <= wr_data[7:3];
          3'd2: trig    <= wr_data;
          3'd3: rotate  <= wr_data[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = irr;
      2'd1:    rd_data = isr;
      2'd2:    rd_data = mask;
      default: rd_data = req_ok ? {1'b1, 4'b0000, req_lvl} : 8'd0;
    endcase
  end

  AST_GRANT_NOT_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> !isr[req_lvl]); // R3
  AST_ACK_MARKS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> isr[$past(req_lvl)]); // R4
  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(isr & ~$past(isr)) <= 1); // R4
  AST_DROP_NEEDS_EOI: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(isr) & ~isr)) |-> $past(eoi)); // R8

endmodule

// File: tb/irq_arbiter8_test.sv
module irq_arbiter8_test;
  logic clk = 0, rst_n = 0;
  logic [7:0] irq_in = 0, wr_data = 0;
  logic [2:0] wr_addr = 0;
  logic [1:0] rd_addr = 0;
  logic wr_en = 0, ack = 0;
  logic [7:0] rd_data, vec_o;
  logic int_o;
  int total = 0, errs = 0;
  bit done = 0;

  irq_arbiter8 uut (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ack(ack), .int_o(int_o), .vec_o(vec_o));

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic lines(input logic [7:0] v);
    @(negedge clk); irq_in = v;
    @(negedge clk);
  endtask

  task automatic do_ack;
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  function automatic logic [2:0] lsb(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return 3'(i);
    return 3'd0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; errs++;
      $display("FAIL watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, errs);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] rem;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    rd(0, d); check("R10 pending", d, 8'h00);
    rd(1, d); check("R10 isr", d, 8'h00);
    rd(2, d); check("R10 mask", d, 8'h00);
    rd(3, d); check("R10 poll", d, 8'h00);
    check("R10 int", {7'd0, int_o}, 8'd0);
    // R10 default edge trigger and fixed priority
    lines(8'h06); lines(8'h00);
    rd(0, d); check("R10 edge default", d, 8'h06);
    check("R10 fixed default vec", vec_o, 8'h01);
    do_ack; wr(4, 8'h00); do_ack; wr(4, 8'h00);

    // R4 ack while int low is ignored
    do_ack;
    rd(1, d); check("R4 ignored ack", d, 8'h00);

    // R5 R6 R4 R8 fixed priority sweep over all patterns
    for (int p = 1; p < 256; p++) begin
      wr(1, 8'(p));
      lines(8'(p)); lines(8'h00);
      rem = 8'(p);
      while (rem != 0) begin
        check("R6 int", {7'd0, int_o}, 8'd1);
        check("R5 R6 vec", vec_o, {rem == 0 ? 5'd0 : 5'(p >> 3), lsb(rem)});
        do_ack;
        rd(1, d); check("R4 isr set", d, 8'b1 << lsb(rem));
        rd(0, d); check("R4 pending cleared", d, rem & ~(8'b1 << lsb(rem)));
        wr(4, 8'h00);
        rem = rem & ~(8'b1 << lsb(rem));
      end
      rd(1, d); check("R8 isr empty", d, 8'h00);
      check("R3 idle int", {7'd0, int_o}, 8'd0);
    end
    wr(1, 8'h00);

    // R1 R9 R2 mask sweep with all lines level-high
    wr(2, 8'h00);
    lines(8'hFF);
    for (int m = 0; m < 256; m++) begin
      wr(0, 8'(m));
      check("R1 int", {7'd0, int_o}, (m != 255) ? 8'd1 : 8'd0);
      rd(3, d); check("R9 poll", d, (m != 255) ? {5'b10000, lsb(~8'(m))} : 8'h00);
      rd(0, d); check("R1 pending visible", d, 8'hFF);
      rd(2, d); check("R1 mask read", d, 8'(m));
      rd(1, d); check("R9 no side effect", d, 8'h00);
    end
    wr(0, 8'h00);
    lines(8'h00);
    rd(0, d); check("R2 level follows line", d, 8'h00);

    // R2 edge hold then switch to level
    wr(2, 8'hFF);
    lines(8'h10); lines(8'h00);
    rd(0, d); check("R2 edge held", d, 8'h10);
    wr(2, 8'h00);
    lines(8'h00);
    rd(0, d); check("R2 level clears", d, 8'h00);
    wr(2, 8'hFF);

    // R3 R8 nesting over every in-service / request pair
    for (int s = 0; s < 8; s++) begin
      for (int r = 0; r < 8; r++) begin
        lines(8'b1 << s); lines(8'h00);
        do_ack;
        lines(8'b1 << r); lines(8'h00);
        check("R3 nest int", {7'd0, int_o}, (r < s) ? 8'd1 : 8'd0);
        wr(4, 8'h08 | 8'(s));
        rd(1, d); check("R8 specific eoi", d, 8'h00);
        check("R3 after eoi vec", vec_o, {5'd0, 3'(r)});
        do_ack;
        wr(4, 8'h08 | 8'(r));
        check("R3 clean int", {7'd0, int_o}, 8'd0);
      end
    end

    // R8 non-specific clears most urgent in service
    lines(8'h20); lines(8'h00); do_ack;
    lines(8'h04); lines(8'h00);
    check("R3 nest higher", {7'd0, int_o}, 8'd1);
    do_ack;
    rd(1, d); check("R8 two in service", d, 8'h24);
    wr(4, 8'h00);
    rd(1, d); check("R8 nonspecific", d, 8'h20);
    wr(4, 8'h00);
    rd(1, d); check("R8 nonspecific last", d, 8'h00);

    // R7 rotating priority
    wr(3, 8'h01);
    for (int L = 0; L < 8; L++) begin
      lines(8'b1 << L); lines(8'h00);
      do_ack; wr(4, 8'h00);
      lines(8'hFF); lines(8'h00);
      for (int k = 0; k < 8; k++) begin
        check("R7 rot int", {7'd0, int_o}, 8'd1);
        check("R7 rot vec", vec_o, {5'd0, 3'((L + 1 + k) % 8)});
        do_ack; wr(4, 8'h00);
      end
      check("R7 rot idle", {7'd0, int_o}, 8'd0);
    end
    wr(3, 8'h00);
    lines(8'h81); lines(8'h00);
    check("R6 back to fixed", vec_o, 8'h00);
    do_ack; wr(4, 8'h00); do_ack; wr(4, 8'h00);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, errs);
    $finish;
  end
endmodule